// File: doc/BRIEF.md
# Short Error-Frame Suppression Filter

This block sits between a receive deframer and the receive FIFO. It holds the bytes of the frame in progress in a small ring buffer. At the end of each frame it decides whether to release those bytes to the FIFO or throw them away. A frame is thrown away only when suppression is enabled, the frame carried fewer than `THRESH` data bytes (default 3), and at least one of its four receive error flags is set. Such short, corrupted frames are usually produced by electromagnetic disturbance rather than by a real card.

A discarded frame produces no FIFO write and no end-of-receive interrupt. Instead, a one-cycle `rearm` pulse returns the receiver to its awaiting-frame state, and a saturating discard counter steps up by one. Every other frame is released in arrival order. Its interrupt follows the last byte written, together with that frame's error flags. Once a frame reaches `THRESH` bytes it can no longer be discarded, so its bytes stream out at once, one per cycle.

Top module: `short_frame_filter`

## Requirements
- R1: While reset is applied and after it is released, `fifo_wr`, `end_irq` and `rearm` are low and `drop_cnt` is 0. Bytes of a frame cut by reset are never written.
- R2: With `suppress_en` low, every frame is committed regardless of its length or error flags.
- R3: A frame with `THRESH` or more bytes is committed even when its error flags are set.
- R4: A frame with fewer than `THRESH` bytes and no error flag is committed.
- R5: With `suppress_en` high, a frame with fewer than `THRESH` bytes and any one of the error flags set is discarded. The flags are `rx_err[0]` CRC, `[1]` framing, `[2]` parity and `[3]` collision. A discarded frame writes no byte, raises no `end_irq`, and raises `rearm` for exactly one cycle.
- R6: Committed bytes appear on `fifo_byte` with `fifo_wr` high, one per cycle, in arrival order.
- R7: `drop_cnt` increments by one on each discard and saturates at 2^`CNT_W`-1.
- R8: For a committed frame, `end_irq` pulses once after its last byte has been written. In that cycle `end_err` equals the frame's `rx_err`.
- R9: A byte presented in the same cycle as `rx_end` belongs to that frame and counts toward `THRESH`.
- R10: A frame of zero bytes is discarded if it has an error and suppression is on. Otherwise it raises only `end_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| suppress_en | input | 1 | Enables discard of short erroneous frames |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| rx_end | input | 1 | End of frame; `rx_err` is valid |
| rx_err | input | 4 | Error flags: [0] CRC, [1] framing, [2] parity, [3] collision |
| fifo_wr | output | 1 | Write strobe toward the receive FIFO |
| fifo_byte | output | 8 | Byte written to the FIFO |
| end_irq | output | 1 | End-of-receive interrupt pulse for a committed frame |
| end_err | output | 4 | Error flags of the committed frame, valid with `end_irq` |
| rearm | output | 1 | One-cycle pulse: frame discarded, receiver back to awaiting |
| drop_cnt | output | CNT_W | Saturating count of discarded frames |

## Verification
The bench builds the block with `CNT_W = 2` and the default `THRESH = 3`. With these values, a handful of discards is enough to drive the counter to its ceiling of 3 and then past it. Frames of 0 to 5 bytes are driven back to back, one byte per cycle. This covers lengths both below and above the threshold, and exercises the ring at its maximum occupancy while it streams a long frame. The bench also places the end marker on the third byte itself, to land exactly on the boundary.

// File: rtl/sff_pkg.sv
package sff_pkg;
  localparam int ERR_W  = 4;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic col;
    logic par;
    logic frm;
    logic crc;
  } rx_err_t;

  function automatic logic err_any(input rx_err_t e);
    return e.col | e.par | e.frm | e.crc;
  endfunction
endpackage

// File: rtl/sff_rst_sync.sv
module sff_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/sff_decide.sv
module sff_decide #(
  parameter int THRESH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             byte_vld,
  input  logic             frame_end,
  input  sff_pkg::rx_err_t err,
  output logic             commit_o,
  output logic             drop_o
);
  localparam int CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] TH = CW'(THRESH);

  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          short_frame;

  always_comb begin
    cnt_inc = (byte_vld && cnt_q != TH) ? cnt_q + 1'b1 : cnt_q;
    short_frame = cnt_inc < TH;
    drop_o = frame_end && en && short_frame && sff_pkg::err_any(err);
    commit_o = (byte_vld && !short_frame) || (frame_end && !drop_o);
    cnt_d = frame_end ? '0 : cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  long_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && cnt_q == TH) |-> !drop_o);
endmodule

// File: rtl/sff_ring.sv
module sff_ring #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         commit,
  input  logic         rollback,
  output logic         rd_vld,
  output logic [W-1:0] rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_q, cm_q, rd_q;
  logic [AW:0]  wr_d, cm_d, rd_d, wr_inc;

  always_comb begin
    wr_inc = wr_q + {{AW{1'b0}}, wr_en};
    wr_d   = rollback ? cm_q : wr_inc;
    cm_d   = commit ? wr_inc : cm_q;
    rd_vld = rd_q != cm_q;
    rd_d   = rd_q + {{AW{1'b0}}, rd_vld};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      cm_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      cm_q <= cm_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !rollback) mem[wr_q[AW-1:0]] <= wr_data;
  end

  assign rd_data = mem[rd_q[AW-1:0]];

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_q - rd_q) < CAP);

  // R5
  rollback_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rollback |-> !commit);
endmodule

// File: rtl/sff_satcnt.sv
module sff_satcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb cnt_d = (inc && !(&cnt)) ? cnt + 1'b1 : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R7
  sat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (cnt == $past(cnt) + 1'b1) || (&cnt && &$past(cnt)));
endmodule

// File: rtl/short_frame_filter.sv
module short_frame_filter #(
  parameter int THRESH = 3,
  parameter int CNT_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       suppress_en,
  input  logic                       rx_valid,
  input  logic [sff_pkg::BYTE_W-1:0] rx_byte,
  input  logic                       rx_end,
  input  logic [sff_pkg::ERR_W-1:0]  rx_err,
  output logic                       fifo_wr,
  output logic [sff_pkg::BYTE_W-1:0] fifo_byte,
  output logic                       end_irq,
  output logic [sff_pkg::ERR_W-1:0]  end_err,
  output logic                       rearm,
  output logic [CNT_W-1:0]           drop_cnt
);
  localparam int DEPTH = 2 ** $clog2(THRESH + 1);

  logic rst_i;
  logic commit, drop;
  logic irq_pend_q, irq_pend_d, rearm_d;
  logic [sff_pkg::ERR_W-1:0] err_q, err_d;

  sff_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_i));

  sff_decide #(.THRESH(THRESH)) u_decide (
    .clk(clk), .rst_n(rst_i), .en(suppress_en),
    .byte_vld(rx_valid), .frame_end(rx_end),
    .err(sff_pkg::rx_err_t'(rx_err)),
    .commit_o(commit), .drop_o(drop)
  );

  sff_ring #(.DEPTH(DEPTH), .W(sff_pkg::BYTE_W)) u_ring (
    .clk(clk), .rst_n(rst_i), .wr_en(rx_valid), .wr_data(rx_byte),
    .commit(commit), .rollback(drop),
    .rd_vld(fifo_wr), .rd_data(fifo_byte)
  );

  sff_satcnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_i), .inc(drop), .cnt(drop_cnt)
  );

  always_comb begin
    end_irq    = irq_pend_q && !fifo_wr;
    irq_pend_d = irq_pend_q && !end_irq;
    err_d      = err_q;
    if (rx_end && !drop) begin
      irq_pend_d = 1'b1;
      err_d      = rx_err;
    end
    rearm_d = drop;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      irq_pend_q <= 1'b0;
      err_q      <= '0;
      rearm      <= 1'b0;
    end else begin
      irq_pend_q <= irq_pend_d;
      err_q      <= err_d;
      rearm      <= rearm_d;
    end
  end

  assign end_err = err_q;

  // R2
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (rx_end && !suppress_en) |=> !rearm);
endmodule

// File: tb/test_short_frame_filter.sv
`timescale 1ns/1ps
module test_short_frame_filter;
  localparam int CNT_W = 2;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n, suppress_en, rx_valid, rx_end;
  logic [7:0] rx_byte;
  logic [3:0] rx_err;
  logic fifo_wr, end_irq, rearm;
  logic [7:0] fifo_byte;
  logic [3:0] end_err;
  logic [CNT_W-1:0] drop_cnt;

  always #2 clk = ~clk;

  short_frame_filter #(.THRESH(3), .CNT_W(CNT_W)) i_short_frame_filter (
    .clk(clk), .rst_n(rst_n), .suppress_en(suppress_en),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_end(rx_end), .rx_err(rx_err),
    .fifo_wr(fifo_wr), .fifo_byte(fifo_byte), .end_irq(end_irq),
    .end_err(end_err), .rearm(rearm), .drop_cnt(drop_cnt)
  );

  int total = 0, fails = 0;
  logic [7:0] got [256];
  int got_n = 0, irq_n = 0, rearm_n = 0;
  logic [3:0] got_err = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_wr) begin got[got_n[7:0]] = fifo_byte; got_n++; end
      if (end_irq) begin irq_n++; got_err = end_err; end
      if (rearm) rearm_n++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // {en, end_with_last_byte, nbytes[2:0], err[3:0]}
  localparam logic [8:0] VEC [12] = '{
    9'b1_0_010_0000,  // R4 short clean
    9'b1_0_010_0001,  // R5 crc
    9'b1_1_001_0010,  // R5 R9 framing, byte with end
    9'b1_0_011_1000,  // R3 long with collision
    9'b0_0_001_0100,  // R2 disabled
    9'b1_0_000_1000,  // R10 empty with error
    9'b1_1_010_0100,  // R5 parity, byte with end
    9'b1_1_011_0001,  // R9 R3 third byte with end
    9'b1_0_101_1111,  // R3 R6 five bytes
    9'b1_0_001_1000,  // R7 saturation
    9'b0_0_000_0011,  // R2 R10 disabled empty
    9'b1_0_000_0000   // R10 empty clean
  };

  function automatic logic [7:0] bval(input int idx, input int j);
    return 8'((idx << 4) | j);
  endfunction

  task automatic drive(input logic en, input logic tog, input int n,
                       input logic [3:0] err, input int idx);
    @(negedge clk) suppress_en = en;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = bval(idx, j);
      if (tog && j == n - 1) begin rx_end = 1'b1; rx_err = err; end
    end
    if (!(tog && n > 0)) begin
      @(negedge clk);
      rx_valid = 1'b0; rx_end = 1'b1; rx_err = err;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_end = 1'b0; rx_err = '0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int drops;
    drops = 0;
    rst_n = 1'b0; suppress_en = 1'b0; rx_valid = 1'b0; rx_end = 1'b0;
    rx_byte = '0; rx_err = '0;
    repeat (3) @(negedge clk);
    check("R1 fifo_wr in reset", int'(fifo_wr), 0);
    check("R1 end_irq in reset", int'(end_irq), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 rearm after reset", int'(rearm), 0);
    check("R1 drop_cnt after reset", int'(drop_cnt), 0);

    for (int i = 0; i < 12; i++) begin
      logic en, tog, keep;
      int n, b_got, b_irq, b_rearm, ok;
      logic [3:0] err;
      en = VEC[i][8]; tog = VEC[i][7]; n = int'(VEC[i][6:4]); err = VEC[i][3:0];
      keep = !en || n >= 3 || err == 4'b0;
      b_got = got_n; b_irq = irq_n; b_rearm = rearm_n;
      drive(en, tog, n, err, i);
      if (!keep) drops++;
      check($sformatf("R2/R3/R4/R5 bytes written vec %0d", i), got_n - b_got, keep ? n : 0);
      ok = 1;
      if (keep) for (int j = 0; j < n; j++)
        if (got[8'(b_got + j)] != bval(i, j)) ok = 0;
      check($sformatf("R6 byte order vec %0d", i), ok, 1);
      check($sformatf("R8 irq count vec %0d", i), irq_n - b_irq, keep ? 1 : 0);
      if (keep) check($sformatf("R8 end_err vec %0d", i), int'(got_err), int'(err));
      check($sformatf("R5 rearm count vec %0d", i), rearm_n - b_rearm, keep ? 0 : 1);
      check($sformatf("R7 drop_cnt vec %0d", i), int'(drop_cnt), drops > MAXC ? MAXC : drops);
    end

    // R1: reset in the middle of a frame drops its pending bytes
    begin
      int b_got, ok;
      b_got = got_n;
      @(negedge clk) suppress_en = 1'b1;
      for (int j = 0; j < 2; j++) begin
        @(negedge clk); rx_valid = 1'b1; rx_byte = bval(13, j);
      end
      @(negedge clk); rx_valid = 1'b0; rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 drop_cnt cleared", int'(drop_cnt), 0);
      check("R1 no stale bytes", got_n - b_got, 0);
      drive(1'b1, 1'b0, 2, 4'b0000, 12);
      check("R1 R4 clean frame after reset", got_n - b_got, 2);
      ok = (got[8'(b_got)] == bval(12, 0)) && (got[8'(b_got + 1)] == bval(12, 1));
      check("R1 R6 bytes after reset", ok, 1);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule